// File: doc/BRIEF.md
# Encoder Event Interval Timer

This block measures how many system clocks elapse across a group of consecutive encoder edges. Velocity estimation at low shaft speed then needs only one division of a known edge count by a measured time. A filtered, one-clock encoder edge strobe enters the block. The first strobe after the block is armed becomes the reference edge. The block then counts clocks until a programmed number of further edges has arrived, from 1 to 255. At that point it stores the elapsed count in a holding register and raises a one-clock ready pulse. The closing edge of one group is at once the reference edge of the next, so back-to-back groups leave no gap in time.

The interval counter saturates rather than wrapping. A sticky overflow flag records that the count saturated. A sticky overrun flag records that a capture replaced a value that had not been acknowledged through the read strobe. Setting the group size to zero, or dropping the enable, stops measurement. Either one also discards any partial group and clears both sticky flags. The holding register keeps its last value.

Top module: `enc_event_timer`

## Requirements
- R1: After synchronous reset, `interval` is 0 and `ready`, `ovf` and `overrun` are all 0.
- R2: With a group size of 1, each edge after the reference edge produces a capture equal to the number of clock cycles between that edge's strobe and the previous edge's strobe.
- R3: With a group size of N, the capture equals the number of clock cycles from the reference strobe to the Nth following strobe. That closing strobe becomes the next reference. `ready` is high for exactly one cycle, in the same cycle that `interval` shows the new value.
- R4: While `enable` is 0 or `group_cnt` is 0, edge strobes produce no `ready` pulse and `interval` keeps its value.
- R5: The interval counter stops at its all-ones value (2^CNT_W-1). `ovf` sets once the counter is held there. `ovf` stays set across later captures while the block remains active.
- R6: A capture that occurs while the previous capture is still unread sets the sticky `overrun`. A capture is marked as read by a `rd_stb` pulse, which may arrive any cycle up to and including the next capture cycle.
- R7: Dropping `enable` clears `ovf` and `overrun` and discards a partial group. After re-enable, the first strobe is a fresh reference edge.
- R8: A group size of 255 is accepted. 256 strobes on consecutive cycles yield a single capture of 255 with no overflow when CNT_W exceeds 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Measurement enable |
| group_cnt | input | EVT_W | Edges per measurement; 0 stops measurement |
| edge_stb | input | 1 | One-clock strobe per filtered encoder edge |
| rd_stb | input | 1 | Acknowledges that the held interval was read |
| interval | output | CNT_W | Held elapsed clock count of the last group |
| ready | output | 1 | One-clock pulse on each new capture |
| ovf | output | 1 | Sticky: interval counter saturated |
| overrun | output | 1 | Sticky: capture replaced an unread value |

## Verification
A wrong edge count inside the grouper appears at the ports at the next capture. The `ready` pulse comes one or more edges early or late, and `interval` shows a multiple of the edge gap other than N. A timer that fails to restart on the shared closing edge shows up on the second capture of a run with uneven gaps, because the value carries clocks from the earlier group. Errors in the sticky flags, such as a flag that never sets or one that survives a disable, are visible one clock after the edge that sets them or one clock after `enable` falls.

// File: rtl/eet_pkg.sv
// Package: shared types for the encoder event interval timer.
// Assumes: nothing beyond IEEE 1800-2017.
package eet_pkg;
    // Arming state of the edge grouper.
    typedef enum logic {
        GRP_IDLE  = 1'b0,
        GRP_ARMED = 1'b1
    } grp_state_e;
endpackage

// File: rtl/eet_edge_grouper.sv
// Module: counts encoder edge strobes into groups of group_cnt edges.
// It produces a restart strobe on the reference and closing edges and a
// capture strobe on each closing edge.
// Assumes: edge_stb is a clean one-clock strobe; 'active' already folds in
// enable and a non-zero group size.
module eet_edge_grouper
    import eet_pkg::*;
#(
    parameter int EVT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             edge_stb,
    input  logic [EVT_W-1:0] group_cnt,
    output logic             armed,
    output logic             start,
    output logic             capture
);
    localparam int CMP_W = EVT_W + 1;

    grp_state_e       state_q;
    logic [EVT_W-1:0] ecnt_q;
    logic             last_edge;

    // Decide whether the current edge closes the group (>= tolerates a shrink).
    always_comb begin
        last_edge = ({1'b0, ecnt_q} + CMP_W'(1)) >= {1'b0, group_cnt};
        armed     = (state_q == GRP_ARMED);
        capture   = active && armed && edge_stb && last_edge;
        start     = active && edge_stb && (!armed || last_edge);
    end

    // Track arming and the number of edges seen since the reference edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            state_q <= GRP_IDLE;
            ecnt_q  <= '0;
        end else if (edge_stb) begin
            if (state_q == GRP_IDLE) begin
                state_q <= GRP_ARMED;
                ecnt_q  <= '0;
            end else if (last_edge) begin
                ecnt_q  <= '0;
            end else begin
                ecnt_q  <= ecnt_q + EVT_W'(1);
            end
        end
    end

    // R3: every capture also restarts the timer from the same edge.
    assert_capture_restarts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> start);
    // R7: an inactive block never stays armed.
    assert_idle_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !armed);
endmodule

// File: rtl/eet_interval_ctr.sv
// Module: saturating interval counter with sticky overflow.
// Loads 1 on a restart edge so that the value equals the clocks elapsed since
// that edge, and holds at all ones.
// Assumes: start is only asserted while active.
module eet_interval_ctr #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             armed,
    input  logic             start,
    output logic [CNT_W-1:0] tmr,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic at_max;

    // Flag that the counter has reached its ceiling.
    always_comb at_max = (tmr == CNT_MAX);

    // Count clocks since the last restart edge, holding at the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            tmr <= '0;
        end else if (start) begin
            tmr <= CNT_W'(1);
        end else if (armed && !at_max) begin
            tmr <= tmr + CNT_W'(1);
        end
    end

    // Latch overflow once a running count sits at the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            ovf <= 1'b0;
        end else if (armed && !start && at_max) begin
            ovf <= 1'b1;
        end
    end

    // R5: the counter never wraps past all ones.
    assert_saturate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && armed && !start && at_max) |=> (tmr == CNT_MAX));
    // R5: overflow stays set while the block stays active.
    assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && active) |=> ovf);
    // R3: a restart edge resets the elapsed count.
    assert_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (tmr == CNT_W'(1)));
endmodule

// File: rtl/eet_capture_reg.sv
// Module: holding register, ready pulse and unread-capture tracking.
// Assumes: a rd_stb in the same cycle as a capture acknowledges the value
// being replaced, not the new one.
module eet_capture_reg #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             capture,
    input  logic             rd_stb,
    input  logic [CNT_W-1:0] tmr,
    output logic [CNT_W-1:0] interval,
    output logic             ready,
    output logic             overrun
);
    logic pending_q;

    // Hold the latest captured interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            interval <= '0;
        end else if (capture) begin
            interval <= tmr;
        end
    end

    // One-clock ready pulse aligned with the holding register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready <= 1'b0;
        end else begin
            ready <= capture;
        end
    end

    // Remember whether the held value has been acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            pending_q <= 1'b0;
        end else if (capture) begin
            pending_q <= 1'b1;
        end else if (rd_stb) begin
            pending_q <= 1'b0;
        end
    end

    // Latch overrun when an unread value is overwritten.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            overrun <= 1'b0;
        end else if (capture && pending_q && !rd_stb) begin
            overrun <= 1'b1;
        end
    end

    // R6: overrun can only rise together with a new capture.
    assert_overrun_on_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> ready);
    // R4: no ready pulse follows an inactive cycle.
    assert_no_ready_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !ready);
    // R4: the holding register is unchanged without a ready pulse.
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> $stable(interval) || !$past(rst_n));
endmodule

// File: rtl/enc_event_timer.sv
// Module: top of the encoder event interval timer.
// It measures system clocks across a programmable group of encoder edges
// and presents the result with a ready pulse and sticky status.
// Assumes: edge_stb is already filtered and synchronous to clk.
module enc_event_timer #(
    parameter int CNT_W = 32,
    parameter int EVT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [EVT_W-1:0] group_cnt,
    input  logic             edge_stb,
    input  logic             rd_stb,
    output logic [CNT_W-1:0] interval,
    output logic             ready,
    output logic             ovf,
    output logic             overrun
);
    logic             active;
    logic             armed;
    logic             start;
    logic             capture;
    logic [CNT_W-1:0] tmr;

    // A group size of zero switches measurement off.
    always_comb active = enable && (group_cnt != '0);

    eet_edge_grouper #(.EVT_W(EVT_W)) u_grouper (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .edge_stb (edge_stb),
        .group_cnt(group_cnt),
        .armed    (armed),
        .start    (start),
        .capture  (capture)
    );

    eet_interval_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .active(active),
        .armed (armed),
        .start (start),
        .tmr   (tmr),
        .ovf   (ovf)
    );

    eet_capture_reg #(.CNT_W(CNT_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (active),
        .capture (capture),
        .rd_stb  (rd_stb),
        .tmr     (tmr),
        .interval(interval),
        .ready   (ready),
        .overrun (overrun)
    );

    // R7: sticky flags are clear one cycle after the block goes inactive.
    assert_clear_on_disable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (!ovf && !overrun));
endmodule

// File: tb/tb_enc_event_timer.sv
module tb_enc_event_timer;
    localparam int CNT_W = 10;
    localparam int EVT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b0;
    logic [EVT_W-1:0] group_cnt = '0;
    logic             edge_stb = 1'b0;
    logic             rd_stb = 1'b1;
    logic [CNT_W-1:0] interval;
    logic             ready;
    logic             ovf;
    logic             overrun;

    int total = 0;
    int bad = 0;
    int n_rdy = 0;
    int first_iv = 0;
    int last_iv = 0;
    bit done = 0;

    enc_event_timer #(.CNT_W(CNT_W), .EVT_W(EVT_W)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .group_cnt(group_cnt),
        .edge_stb(edge_stb), .rd_stb(rd_stb), .interval(interval),
        .ready(ready), .ovf(ovf), .overrun(overrun)
    );

    always #10 clk = ~clk;

    // Record ready pulses away from the active edge.
    always @(negedge clk) begin
        if (ready) begin
            if (n_rdy == 0) first_iv = int'(interval);
            last_iv = int'(interval);
            n_rdy = n_rdy + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic rearm(input int g);
        enable = 1'b0;
        group_cnt = EVT_W'(g);
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        n_rdy = 0;
        first_iv = 0;
        last_iv = 0;
    endtask

    // One strobe, followed by gap-1 quiet cycles.
    task automatic pulse(input int gap);
        edge_stb = 1'b1;
        @(negedge clk);
        edge_stb = 1'b0;
        repeat (gap - 1) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 interval", int'(interval), 0);
        chk("R1 ready", int'(ready), 0);
        chk("R1 ovf", int'(ovf), 0);
        chk("R1 overrun", int'(overrun), 0);
    endtask

    task automatic t_single();
        rearm(1);
        for (int i = 0; i < 4; i++) pulse(5);
        chk("R2 captures", n_rdy, 3);
        chk("R2 value", last_iv, 5);
        chk("R2 held", int'(interval), 5);
    endtask

    task automatic t_group4();
        rearm(4);
        for (int i = 0; i < 9; i++) pulse(7);
        chk("R3 captures", n_rdy, 2);
        chk("R3 value", last_iv, 28);
        chk("R3 ready low after", int'(ready), 0);
    endtask

    task automatic t_shared();
        rearm(2);
        pulse(3); pulse(4); pulse(5); pulse(6); pulse(2);
        chk("R3 shared captures", n_rdy, 2);
        chk("R3 shared first", first_iv, 7);
        chk("R3 shared second", last_iv, 11);
    endtask

    task automatic t_max_group();
        rearm(255);
        for (int i = 0; i < 256; i++) pulse(1);
        repeat (3) @(negedge clk);
        chk("R8 captures", n_rdy, 1);
        chk("R8 value", last_iv, 255);
        chk("R8 no ovf", int'(ovf), 0);
    endtask

    task automatic t_off();
        rearm(0);
        for (int i = 0; i < 5; i++) pulse(3);
        chk("R4 zero group ready", n_rdy, 0);
        chk("R4 zero group held", int'(interval), 255);
        enable = 1'b0;
        group_cnt = 8'd1;
        @(negedge clk);
        for (int i = 0; i < 5; i++) pulse(3);
        chk("R4 disabled ready", n_rdy, 0);
        chk("R4 disabled held", int'(interval), 255);
    endtask

    task automatic t_overflow();
        rearm(1);
        pulse(1100);
        chk("R5 ovf set", int'(ovf), 1);
        chk("R5 no early capture", n_rdy, 0);
        pulse(4);
        chk("R5 saturated value", last_iv, 1023);
        pulse(4);
        chk("R5 next value", last_iv, 4);
        chk("R5 ovf sticky", int'(ovf), 1);
        enable = 1'b0;
        @(negedge clk);
        chk("R7 ovf cleared", int'(ovf), 0);
    endtask

    task automatic t_overrun();
        rearm(1);
        rd_stb = 1'b0;
        pulse(3); pulse(3);
        chk("R6 single capture no overrun", int'(overrun), 0);
        pulse(3);
        chk("R6 overrun set", int'(overrun), 1);
        chk("R6 latest kept", last_iv, 3);
        rd_stb = 1'b1;
        pulse(3);
        chk("R6 overrun sticky", int'(overrun), 1);
        enable = 1'b0;
        @(negedge clk);
        chk("R7 overrun cleared", int'(overrun), 0);
        rearm(1);
        for (int i = 0; i < 4; i++) pulse(3);
        chk("R6 read each time", int'(overrun), 0);
    endtask

    task automatic t_rearm();
        rearm(2);
        pulse(3); pulse(3);
        enable = 1'b0;
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        pulse(3); pulse(3);
        chk("R7 partial discarded", n_rdy, 0);
        pulse(3);
        chk("R7 fresh reference", n_rdy, 1);
        chk("R7 value", last_iv, 6);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_group4();
        t_shared();
        t_max_group();
        t_off();
        t_overflow();
        t_overrun();
        t_rearm();
        done = 1;
        report();
    end
endmodule